// File: doc/BRIEF.md
# Reset Sequencer with Clock-Branch Gating

This block turns an asynchronous, active-low external reset into a synchronous system reset. It also drives the enables and behavioural gated clocks for five clock branches. The external reset is captured by a chain of flip-flops. Each flop is cleared at once by the reset input and is stepped to the released state only while the system clock toggles. After the chain reports the release, a counter holds the system reset asserted for a fixed number of further clock cycles. While the reset sequence runs, every branch enable is forced on, so the downstream logic receives clock edges and can take its own synchronous reset.

A one-byte control register holds the software branch enables, four spare bits and a hold bit for the slow 32 kHz domain. The register sits on a simple address, write-data and write-strobe bus, and reads are combinational. Each disabled branch is gated with an OR, so it parks high. The processor-core branch runs in inverse phase and is enabled by the clocks-unstable indicator rather than by the register. The register-write branch runs only in cycles that carry a write strobe. The slow-domain reset output stays asserted until software clears its bit.

Top module: `rst_gate_seq`

## Requirements
- R1: The external reset is captured by a two-stage flop chain that is cleared asynchronously. If the system clock is stopped, `sysReset` stays asserted after `extRstN` rises, and it stays asserted until the clock runs again.
- R2: After `extRstN` rises with the clock running, `sysReset` is still high after the 5th rising edge and is low after the 6th rising edge: 2 edges for the capture chain plus 4 edges of stretch.
- R3: `sysReset` asserts immediately when `extRstN` falls, with no clock edge needed. It stays asserted through the whole sequence.
- R4: While `sysReset` is high, all five bits of `gateEn` are 1, whatever the register contents, the write strobe or `clocksUnstable`.
- R5: Each gated clock is the clock ORed with the inverted enable, so a disabled branch holds `gatedClk` at 1. The branch order in `gateEn` and `gatedClk` is: bit 0 core, bit 1 register-write, bit 2 speech, bit 3 ringer, bit 4 codec.
- R6: The core branch (bit 0) is the inverse of `sysClk` when enabled, and it is enabled outside reset exactly when `clocksUnstable` is 0.
- R7: The control register sits at address 0x1440 and resets to 0xFD. A read at any other address returns 0.
- R8: A write with `busWrEn`=1 at address 0x1440 loads the whole byte at the next rising edge. A write to another address, or a write at an edge where `sysReset` is high, leaves the register unchanged.
- R9: Register bits 0, 1 and 2 enable the speech, ringer and codec branches. Bits 6..3 read back as written and have no effect on any enable.
- R10: Register bit 7 drives `slowReset` (1 means hold the slow domain in reset). It is set asynchronously by `extRstN` low, is 1 after reset, and changes only through a register write.
- R11: Outside reset, the register-write branch (bit 1) is enabled exactly in cycles where `busWrEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Free-running system clock |
| extRstN | input | 1 | Asynchronous external reset, active low |
| clocksUnstable | input | 1 | High while the clock source is not yet stable; gates the core branch |
| busAddr | input | 16 | Register bus address |
| busWrData | input | 8 | Register bus write data |
| busWrEn | input | 1 | Register bus write strobe |
| busRdData | output | 8 | Register bus read data (combinational) |
| sysReset | output | 1 | Synchronous system reset, active high |
| slowReset | output | 1 | Hold-in-reset for the 32 kHz domain, active high |
| gateEn | output | 5 | Branch enables: core, register-write, speech, ringer, codec |
| gatedClk | output | 5 | Behavioural gated clocks, one per branch |

## Verification
A register write and the end of the reset stretch can fall on the same rising edge. At that edge the sequencer still reports reset, so the register takes its reset value and the write must be lost. The bench provokes this by releasing the external reset and then driving a write of 0x00 to 0x1440 in the cycle just before the 6th rising edge. It judges the result by reading back 0xFD once `sysReset` has dropped, and then by showing that the same write is accepted one cycle later. A second overlap, `clocksUnstable` held high during the sequence, is judged by checking that the core enable stays forced on until reset ends and drops straight after.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  // clock branch positions in gateEn / gatedClk
  localparam int BR_CORE    = 0;
  localparam int BR_REGS    = 1;
  localparam int BR_SPEECH  = 2;
  localparam int BR_RINGER  = 3;
  localparam int BR_CODEC   = 4;
  localparam int NUM_BRANCH = 5;

  // register bit positions for the software-controlled branches
  localparam int BIT_SPEECH = 0;
  localparam int BIT_RINGER = 1;
  localparam int BIT_CODEC  = 2;

  // strobes from the sequencer/decoder to the register datapath
  typedef struct packed {
    logic seqActive;  // reset sequence in progress
    logic wrHit;      // accepted write to the control register
    logic wrAny;      // any write strobe on the bus
    logic rdHit;      // address selects the control register
  } ctrlStrobe_t;

endpackage

// File: rtl/rsc_reset_ctrl.sv
module rsc_reset_ctrl
  import rsc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] REG_ADDR    = 16'h1440,
  parameter int          SYNC_STAGES = 2,
  parameter int          STRETCH     = 4
) (
  input  logic              clk,
  input  logic              extRstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output logic              sysReset,
  output ctrlStrobe_t       strobes
);

  localparam int CNT_W = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH - 1);
  localparam logic [ADDR_W-1:0] MATCH   = ADDR_W'(REG_ADDR);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   latchDone;
  logic [CNT_W-1:0]       stretchCnt;
  logic                   doneQ;
  logic                   addrHit;

  // capture chain: cleared at once, stepped to 1 only by clock edges
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge extRstN) begin
        if (!extRstN) syncQ <= '0;
        else          syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge extRstN) begin
        if (!extRstN) syncQ <= '0;
        else          syncQ <= 1'b1;
      end
    end
  endgenerate

  assign latchDone = syncQ[SYNC_STAGES-1];

  // stretch counter: STRETCH edges after the chain reports release
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN) begin
      stretchCnt <= '0;
      doneQ      <= 1'b0;
    end else if (latchDone && !doneQ) begin
      if (stretchCnt == CNT_LAST) doneQ <= 1'b1;
      else                        stretchCnt <= stretchCnt + 1'b1;
    end
  end

  assign sysReset = !doneQ;

  assign addrHit           = (busAddr == MATCH);
  assign strobes.seqActive = sysReset;
  assign strobes.wrAny     = busWrEn;
  assign strobes.wrHit     = busWrEn && addrHit && !sysReset;
  assign strobes.rdHit     = addrHit;

  // R3
  chain_hold_chk: assert property (@(posedge clk) disable iff (!extRstN)
    !latchDone |-> sysReset);

  // R2
  stretch_len_chk: assert property (@(posedge clk) disable iff (!extRstN)
    $fell(sysReset) |-> ($past(stretchCnt) == CNT_LAST && $past(latchDone)));

  // R8
  wr_block_chk: assert property (@(posedge clk) disable iff (!extRstN)
    sysReset |-> !strobes.wrHit);

endmodule

// File: rtl/rsc_gate_path.sv
module rsc_gate_path
  import rsc_pkg::*;
#(
  parameter int               DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = 8'hFD
) (
  input  logic                  clk,
  input  logic                  extRstN,
  input  logic                  clocksUnstable,
  input  ctrlStrobe_t           strobes,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  output logic                  slowReset,
  output logic [NUM_BRANCH-1:0] gateEn,
  output logic [NUM_BRANCH-1:0] gatedClk
);

  localparam int HOLD_BIT = DATA_W - 1;

  logic [HOLD_BIT-1:0]   lowQ;
  logic                  slowHoldQ;
  logic [DATA_W-1:0]     regView;
  logic [NUM_BRANCH-1:0] branchReq;

  // branch and spare bits: synchronous reset by the sequencer
  always_ff @(posedge clk) begin
    if (strobes.seqActive)  lowQ <= RST_VAL[HOLD_BIT-1:0];
    else if (strobes.wrHit) lowQ <= wrData[HOLD_BIT-1:0];
  end

  // slow-domain hold latch: also set at once by the external reset
  always_ff @(posedge clk or negedge extRstN) begin
    if (!extRstN)               slowHoldQ <= RST_VAL[HOLD_BIT];
    else if (strobes.seqActive) slowHoldQ <= RST_VAL[HOLD_BIT];
    else if (strobes.wrHit)     slowHoldQ <= wrData[HOLD_BIT];
  end

  assign regView   = {slowHoldQ, lowQ};
  assign rdData    = strobes.rdHit ? regView : '0;
  assign slowReset = slowHoldQ;

  // per-branch requests, then forced open during the sequence
  always_comb begin
    branchReq             = '0;
    branchReq[BR_CORE]    = !clocksUnstable;
    branchReq[BR_REGS]    = strobes.wrAny;
    branchReq[BR_SPEECH]  = lowQ[BIT_SPEECH];
    branchReq[BR_RINGER]  = lowQ[BIT_RINGER];
    branchReq[BR_CODEC]   = lowQ[BIT_CODEC];
  end

  assign gateEn = branchReq | {NUM_BRANCH{strobes.seqActive}};

  // behavioural OR gating; core branch runs in inverse phase
  generate
    for (genvar b = 0; b < NUM_BRANCH; b++) begin : g_gate
      if (b == BR_CORE) begin : g_inv
        assign gatedClk[b] = ~clk | ~gateEn[b];
      end else begin : g_std
        assign gatedClk[b] = clk | ~gateEn[b];
      end
    end
  endgenerate

  // R7
  reg_rst_chk: assert property (@(posedge clk) disable iff (!extRstN)
    strobes.seqActive |=> (regView == RST_VAL));

  // R8
  reg_wr_chk: assert property (@(posedge clk) disable iff (!extRstN)
    strobes.wrHit |=> (regView == $past(wrData)));

  // R10
  slow_hold_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (!strobes.wrHit && !strobes.seqActive) |=> $stable(slowReset));

  // R11
  regs_gate_chk: assert property (@(posedge clk) disable iff (!extRstN)
    (!strobes.seqActive && !strobes.wrAny) |-> !gateEn[BR_REGS]);

endmodule

// File: rtl/rst_gate_seq.sv
module rst_gate_seq
  import rsc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter logic [15:0] REG_ADDR    = 16'h1440,
  parameter logic [7:0]  RST_VAL     = 8'hFD,
  parameter int          SYNC_STAGES = 2,
  parameter int          STRETCH     = 4
) (
  input  logic                  sysClk,
  input  logic                  extRstN,
  input  logic                  clocksUnstable,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [DATA_W-1:0]     busWrData,
  input  logic                  busWrEn,
  output logic [DATA_W-1:0]     busRdData,
  output logic                  sysReset,
  output logic                  slowReset,
  output logic [NUM_BRANCH-1:0] gateEn,
  output logic [NUM_BRANCH-1:0] gatedClk
);

  ctrlStrobe_t strobes;

  rsc_reset_ctrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .SYNC_STAGES(SYNC_STAGES), .STRETCH(STRETCH)
  ) u_ctrl (
    .clk(sysClk), .extRstN(extRstN), .busAddr(busAddr),
    .busWrEn(busWrEn), .sysReset(sysReset), .strobes(strobes)
  );

  rsc_gate_path #(
    .DATA_W(DATA_W), .RST_VAL(DATA_W'(RST_VAL))
  ) u_path (
    .clk(sysClk), .extRstN(extRstN), .clocksUnstable(clocksUnstable),
    .strobes(strobes), .wrData(busWrData), .rdData(busRdData),
    .slowReset(slowReset), .gateEn(gateEn), .gatedClk(gatedClk)
  );

endmodule

// File: tb/tb_rst_gate_seq.sv
module tb_rst_gate_seq;

  localparam logic [15:0] REG_A = 16'h1440;

  logic        clk = 1'b0;
  logic        clkRun = 1'b1;
  logic        extRstN = 1'b0;
  logic        clocksUnstable = 1'b0;
  logic [15:0] busAddr = REG_A;
  logic [7:0]  busWrData = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busRdData;
  logic        sysReset, slowReset;
  logic [4:0]  gateEn, gatedClk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = clkRun ? ~clk : 1'b0;

  rst_gate_seq dut (
    .sysClk(clk), .extRstN(extRstN), .clocksUnstable(clocksUnstable),
    .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdData(busRdData), .sysReset(sysReset), .slowReset(slowReset),
    .gateEn(gateEn), .gatedClk(gatedClk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected enables outside reset: {codec, ringer, speech, regs, core}
  function automatic logic [4:0] expEn(input logic [7:0] r, input logic uns, input logic wr);
    return {r[2], r[1], r[0], wr, !uns};
  endfunction

  // release reset and check the R2 timing edge by edge
  task automatic release_and_count();
    @(negedge clk); extRstN = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R2 sysReset after edge %0d", k), sysReset, (k < 6) ? 1 : 0);
    end
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    #1;
    check("R11 regs enable during write", gateEn[1], 1);
    check("R5 regs clock low phase while enabled", gatedClk[1], 0);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = REG_A;
    #1;
    check("R11 regs enable after write", gateEn[1], 0);
    check("R5 regs clock parked high", gatedClk[1], 1);
  endtask

  task automatic t_reset_state();
    clocksUnstable = 1'b1;
    extRstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 sysReset during external reset", sysReset, 1);
    check("R4 all enables forced on", gateEn, 5'h1F);
    check("R10 slowReset during reset", slowReset, 1);
    release_and_count();
    check("R6 core disabled when unstable", gateEn[0], 0);
    clocksUnstable = 1'b0;
    #1;
    check("R7 reset value", busRdData, 8'hFD);
    check("R9 enables from reset value", gateEn, expEn(8'hFD, 1'b0, 1'b0));
    check("R10 slowReset after reset", slowReset, 1);
  endtask

  task automatic t_stopped_clock();
    @(negedge clk); clkRun = 1'b0;
    #15 extRstN = 1'b0;
    #40 check("R3 async assert with clock stopped", sysReset, 1);
    extRstN = 1'b1;
    #100 check("R1 reset held with stopped clock", sysReset, 1);
    check("R1 slow hold with stopped clock", slowReset, 1);
    clkRun = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R1 R2 resume edge %0d", k), sysReset, (k < 6) ? 1 : 0);
    end
  endtask

  task automatic t_reg_access();
    write_reg(REG_A, 8'h7A);
    #1;
    check("R8 readback 0x7A", busRdData, 8'h7A);
    check("R10 slowReset released", slowReset, 0);
    check("R9 only ringer enabled", gateEn, expEn(8'h7A, 1'b0, 1'b0));
    write_reg(REG_A, 8'h02);
    #1;
    check("R9 spare bits read back", busRdData, 8'h02);
    check("R9 spare bits no gating effect", gateEn, expEn(8'h02, 1'b0, 1'b0));
    write_reg(16'h1441, 8'h85);
    #1;
    check("R8 other address write ignored", busRdData, 8'h02);
    busAddr = 16'h1441;
    #1;
    check("R7 other address reads 0", busRdData, 8'h00);
    busAddr = REG_A;
    check("R10 slowReset unchanged by other write", slowReset, 0);
    write_reg(REG_A, 8'h85);
    #1;
    check("R10 slowReset set by write", slowReset, 1);
    check("R9 speech and codec enabled", gateEn, expEn(8'h85, 1'b0, 1'b0));
  endtask

  task automatic t_gating();
    // register holds 0x85: speech, codec on; ringer off
    @(negedge clk); #1;
    check("R5 speech low phase", gatedClk[2], 0);
    check("R5 ringer parked high (clk low)", gatedClk[3], 1);
    check("R6 core high while clk low", gatedClk[0], 1);
    @(posedge clk); #1;
    check("R5 codec high phase", gatedClk[4], 1);
    check("R5 ringer parked high (clk high)", gatedClk[3], 1);
    check("R6 core inverted low while clk high", gatedClk[0], 0);
    clocksUnstable = 1'b1;
    #1;
    check("R6 core disabled parks high", gatedClk[0], 1);
    check("R6 core enable off", gateEn[0], 0);
    @(negedge clk); clocksUnstable = 1'b0;
    #1;
    check("R6 core enable back on", gateEn[0], 1);
  endtask

  task automatic t_collision();
    @(negedge clk); extRstN = 1'b0; clocksUnstable = 1'b1;
    @(negedge clk); extRstN = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R4 core forced on during sequence", gateEn[0], 1);
    end
    busAddr = REG_A; busWrData = 8'h00; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    #1;
    check("R2 reset ended", sysReset, 0);
    check("R8 write on last reset edge ignored", busRdData, 8'hFD);
    check("R6 core off right after reset", gateEn[0], 0);
    clocksUnstable = 1'b0;
    write_reg(REG_A, 8'h00);
    #1;
    check("R8 write accepted after reset", busRdData, 8'h00);
    check("R9 all soft branches off", gateEn, expEn(8'h00, 1'b0, 1'b0));
    @(negedge clk); extRstN = 1'b0;
    #1;
    check("R10 slowReset set by external reset", slowReset, 1);
    check("R4 enables forced on at reset", gateEn, 5'h1F);
    release_and_count();
  endtask

  initial begin
    t_reset_state();
    t_stopped_clock();
    t_reg_access();
    t_gating();
    t_collision();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule